// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers interrupt request lines from a parameterised number of peripheral sources. It decides when a simple in-order CPU must leave its background code and run a service routine. Each rising edge on a source line is captured in a pending flag. A pending source can cause entry only when two things are set: the enable bit for that source and a single global enable. Entry happens only on the cycle the CPU marks the end of an instruction.

On entry the block gives a one-cycle strobe. It tells the CPU to store its next-instruction address and status word and to jump to the vector index the block presents. At the same time the block remembers the global enable and then clears it, so no nested entry can occur. A return strobe from the CPU puts the remembered global enable back. For each source, software chooses whether entry clears that pending flag automatically or whether the flag stays set until software clears it. For each source, software also marks whether a handler exists. A source with no handler is sent to a fixed catch-all vector.

Software reaches the controller through a small word-wide register port with combinational read data. All configuration is zero after reset.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the source enables, the global enable, the auto-clear mask, the handler mask and the pending flags all read 0, and `irq_take_o` is low.
- R2: Entry happens only when `insn_done_i` is high, the global enable is 1, and at least one source has both its pending flag and its enable bit set.
- R3: If `insn_done_i` is high in a cycle where R2 holds, `irq_take_o` is high for exactly the next cycle. It stays low while `insn_done_i` is low.
- R4: The clock edge that raises `irq_take_o` also clears the global enable, so `irq_take_o` never stays high for two cycles in a row.
- R5: When a source is taken and its auto-clear bit (register 2) is 1, its pending flag reads 0 in the cycle where `irq_take_o` is high.
- R6: When a source is taken and its auto-clear bit is 0, its pending flag stays set. After a return, it causes entry again at the next instruction boundary.
- R7: `vec_o` is the taken source index if that source's handler bit (register 3) is 1. Otherwise it is the parameter `DEFAULT_VEC`, which defaults to `NUM_SRC` (16).
- R8: A 0-to-1 transition of `src_i[k]` sets pending bit k, even when source k or the global enable is off. A line held high does not set the flag again after it is cleared.
- R9: When several enabled sources are pending, the lowest-numbered one is taken.
- R10: A one-cycle `reti_i` pulse sets the global enable back to the value stored at the last entry. The result is visible in the next cycle.
- R11: Writing a 1 to register 4 clears that pending bit. If a rising edge on the same source arrives in the same cycle as the clear, the bit stays set.
- R12: Register map (`reg_addr_i`): 0 is the source enables, 1 is the global enable in bit 0, 2 is the auto-clear mask, 3 is the handler mask, and 4 is the pending flags (reads return the flags, writes clear where the data bit is 1). Writes take effect at the clock edge where `reg_we_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Request lines, sampled for rising edges |
| insn_done_i | input | 1 | High in the last cycle of an instruction |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Register read data, combinational |
| irq_take_o | output | 1 | Save-state and redirect strobe |
| vec_o | output | VEC_W | Vector index, held from the last entry |
| gie_o | output | 1 | Current global enable |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a software clear of a pending flag and a new rising edge on that same line. The bench raises the source in the very cycle that it writes the clear, then reads register 4 back and expects the bit to be set. It then clears the bit again with the line still high and expects 0. The second pair is entry and auto-clear. On the edge that raises the strobe, the bench reads the pending flags and expects the taken bit to be gone only in auto-clear mode. A scoreboard queue holds the expected vectors. Any strobe that arrives when no entry is queued counts as a failure, which covers entry without a boundary or while the global enable is off.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 3'd0,
    REG_GIE  = 3'd1,
    REG_AUTO = 3'd2,
    REG_HND  = 3'd3,
    REG_PEND = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               gie_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] auto_o,
  output logic [NUM_SRC-1:0] hnd_o,
  output logic               gie_wr_o,
  output logic               gie_wdata_o,
  output logic [NUM_SRC-1:0] pend_clr_o
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      auto_o <= '0;
      hnd_o  <= '0;
    end else if (we_i) begin
      case (sel)
        REG_EN:   en_o   <= wdata_i;
        REG_AUTO: auto_o <= wdata_i;
        REG_HND:  hnd_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign gie_wr_o    = we_i && (sel == REG_GIE);
  assign gie_wdata_o = wdata_i[0];
  assign pend_clr_o  = (we_i && (sel == REG_PEND)) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_EN:   rdata_o = en_o;
      REG_GIE:  rdata_o[0] = gie_i;
      REG_AUTO: rdata_o = auto_o;
      REG_HND:  rdata_o = hnd_o;
      REG_PEND: rdata_o = pend_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    // a new edge beats any clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     pend_o[k] <= 1'b0;
      else if (rise_o[k])              pend_o[k] <= 1'b1;
      else if (clr_i[k] || ack_i[k])   pend_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  // scan downward so the lowest set index is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned VEC_W       = $clog2(NUM_SRC + 1),
  parameter int unsigned DEFAULT_VEC = NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               insn_done_i,
  input  logic               reti_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_take_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               gie_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_cfg
    $error("irq_ctrl: NUM_SRC must be 1..64");
  end

  logic [NUM_SRC-1:0] en_q, auto_q, hnd_q, pend_q, pend_clr, src_rise, ack_mask;
  logic               gie_q, gie_save_q, gie_wr, gie_wdata;
  logic               any_req, take_d;
  logic [IDX_W-1:0]   win_idx;
  logic [VEC_W-1:0]   vec_d;

  irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pend_i     (pend_q),
    .gie_i      (gie_q),
    .rdata_o    (reg_rdata_o),
    .en_o       (en_q),
    .auto_o     (auto_q),
    .hnd_o      (hnd_q),
    .gie_wr_o   (gie_wr),
    .gie_wdata_o(gie_wdata),
    .pend_clr_o (pend_clr)
  );

  irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .clr_i (pend_clr),
    .ack_i (ack_mask),
    .rise_o(src_rise),
    .pend_o(pend_q)
  );

  irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .req_i(pend_q & en_q),
    .any_o(any_req),
    .idx_o(win_idx)
  );

  assign take_d   = insn_done_i && gie_q && any_req;
  assign ack_mask = take_d ? ((NUM_SRC'(1) << win_idx) & auto_q) : '0;
  assign vec_d    = hnd_q[win_idx] ? VEC_W'(win_idx) : VEC_W'(DEFAULT_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_take_o <= 1'b0;
      vec_o      <= '0;
      gie_q      <= 1'b0;
      gie_save_q <= 1'b0;
    end else begin
      irq_take_o <= take_d;
      if (take_d) begin
        vec_o      <= vec_d;
        gie_save_q <= gie_q;
        gie_q      <= 1'b0;
      end else if (reti_i) begin
        gie_q <= gie_save_q;
      end else if (gie_wr) begin
        gie_q <= gie_wdata;
      end
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               insn_done_i,
  input logic               reti_i,
  input logic               irq_take_o,
  input logic               gie_o,
  input logic               gie_save_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] pend_clr,
  input logic [NUM_SRC-1:0] src_rise
);
  logic ready;
  assign ready = gie_o && |(pend_q & en_q);

  p_take_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> $past(insn_done_i) && $past(ready));

  p_take_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_done_i && ready) |=> irq_take_o);

  p_gie_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> !gie_o);

  p_single_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> !irq_take_o);

  p_edge_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_rise) |=> ((pend_q & $past(src_rise)) == $past(src_rise)));

  p_reti_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(insn_done_i && ready)) |=> (gie_o == $past(gie_save_q)));

  p_clr_vs_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_clr & src_rise)) |=> ((pend_q & $past(pend_clr & src_rise)) == $past(pend_clr & src_rise)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .insn_done_i(insn_done_i),
  .reti_i     (reti_i),
  .irq_take_o (irq_take_o),
  .gie_o      (gie_o),
  .gie_save_q (gie_save_q),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .pend_clr   (pend_clr),
  .src_rise   (src_rise)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int N     = 16;
  localparam int VW    = $clog2(N + 1);
  localparam int DEFV  = N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          done = 1'b0;
  logic          reti = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          take;
  logic [VW-1:0] vec;
  logic          gie;

  int checks = 0;
  int errors = 0;
  int    exp_vec[$];
  string exp_req[$];
  bit    finished = 0;

  always #5 clk = ~clk;

  irq_ctrl #(.NUM_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .insn_done_i(done), .reti_i(reti),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_take_o(take), .vec_o(vec), .gie_o(gie)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && take) begin
      if (exp_vec.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected entry, actual vector %0d expected none", vec);
      end else begin
        string r;
        int e;
        r = exp_req.pop_front();
        e = exp_vec.pop_front();
        chk(r, vec, e);
      end
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic expect_entry(int v, string req);
    exp_vec.push_back(v);
    exp_req.push_back(req);
  endtask

  task automatic boundary(input logic exp_take, input string req);
    done = 1'b1;
    cyc();
    done = 1'b0;
    chk(req, take, exp_take);
  endtask

  task automatic do_reti();
    reti = 1'b1;
    cyc();
    reti = 1'b0;
  endtask

  task automatic rise(input logic [N-1:0] m);
    src = src | m;
    cyc();
    src = src & ~m;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 take low", take, 0);
    chk("R1 gie low", gie, 0);

    // R8 pending latched while disabled
    rise(N'(1) << 3);
    rd(3'd4, v);
    chk("R8 pending while disabled", v, 16'h0008);

    // R2 enabled source but global off: no entry
    wr(3'd0, N'(1) << 3);
    boundary(1'b0, "R2 blocked by global enable");
    rd(3'd4, v);
    chk("R2 pending kept", v, 16'h0008);

    // R12 configuration
    wr(3'd3, 16'h00AC);      // handlers for 2,3,5,7
    wr(3'd2, 16'h068C);      // auto-clear 2,3,7,9,10
    wr(3'd1, 16'h0001);
    rd(3'd1, v);
    chk("R12 global enable readback", v, 1);
    rd(3'd2, v);
    chk("R12 auto mask readback", v, 16'h068C);

    // R3 no entry without boundary
    repeat (3) cyc();
    chk("R3 no take without boundary", take, 0);

    // R5 auto-clear, R4 gie off
    expect_entry(3, "R7 vector of source 3");
    boundary(1'b1, "R3 entry after boundary");
    chk("R4 gie cleared on entry", gie, 0);
    rd(3'd4, v);
    chk("R5 auto-clear on entry", v, 0);
    cyc();
    chk("R4 single strobe", take, 0);

    // R10 restore
    do_reti();
    chk("R10 gie restored", gie, 1);

    // R6 software-clear source retriggers
    wr(3'd0, 16'h0020);
    rise(16'h0020);
    expect_entry(5, "R6 first entry source 5");
    boundary(1'b1, "R6 entry");
    rd(3'd4, v);
    chk("R6 pending kept on entry", v, 16'h0020);
    do_reti();
    expect_entry(5, "R6 re-entry source 5");
    boundary(1'b1, "R6 re-entry after return");
    do_reti();
    wr(3'd4, 16'h0020);
    rd(3'd4, v);
    chk("R11 software clear", v, 0);

    // R9 priority
    wr(3'd0, 16'h0084);
    rise(16'h0084);
    expect_entry(2, "R9 lowest first");
    boundary(1'b1, "R9 entry 2");
    do_reti();
    expect_entry(7, "R9 next source");
    boundary(1'b1, "R9 entry 7");
    do_reti();

    // R7 catch-all
    wr(3'd0, 16'h0200);
    rise(16'h0200);
    expect_entry(DEFV, "R7 default vector");
    boundary(1'b1, "R7 entry unassigned");
    do_reti();

    // R11 clear and edge same cycle
    src[10] = 1'b1;
    wr(3'd4, 16'h0400);
    rd(3'd4, v);
    chk("R11 edge beats clear", v, 16'h0400);
    wr(3'd4, 16'h0400);
    rd(3'd4, v);
    chk("R8 held level no re-set", v, 0);
    src[10] = 1'b0;
    cyc();

    chk("R2 all expected entries seen", exp_vec.size(), 0);
    summary();
  end
endmodule